// File: doc/BRIEF.md
# I2C Target Register Control Port

This block is an I2C target that lets an external bus controller reach a bank of sixteen 8-bit registers kept outside the block. SCL and SDA arrive as raw pins and are synchronized onto the system clock. The block pulls SDA low through an open-drain enable and never drives it high. It recognises start and stop conditions and takes a 7-bit device address whose top five bits are fixed. The two low address bits come from strap pins that are captured during reset.

A write transfer carries a register pointer byte and then any number of data bytes. Each data byte is written through the bank's write port at the current pointer. A read transfer returns bytes from the bank starting at the stored pointer. The pointer moves up by one after every data byte and wraps around. Only a write can load the pointer, and the pointer keeps its value across a stop. To read from a chosen register, the controller therefore first sends a write that it stops right after the pointer byte, and then starts a read.

Top module: `i2cRegPort`

## Requirements
- R1: A falling SDA while SCL is high is a start and begins address reception. A rising SDA while SCL is high is a stop; it ends any transfer, and the target releases SDA.
- R2: The first byte after a start is seven address bits, MSB first, and then a direction bit (1 = read, 0 = write). The target pulls SDA low in the ninth clock only when the address equals binary 10011 followed by the latched strap[1], strap[0].
- R3: The strap pins are sampled while rstN is low. Changing them after reset has no effect on the address that is matched.
- R4: In a write, the byte after the address is the pointer, and its low 4 bits are used. Each later byte is acknowledged and presented once on regWrEn, regWrAddr and regWrData, at the current pointer.
- R5: In a read, the target sends the register at the current pointer (regRdAddr), MSB first, starting with the byte right after the address ACK.
- R6: After every data byte, read or written, the pointer increases by one and wraps from 15 to 0.
- R7: The pointer keeps its value across a stop. A write that is stopped after the pointer byte's ACK leaves the pointer at that value for a later read.
- R8: A read transfer never loads the pointer and never asserts regWrEn.
- R9: When the controller answers a read byte with NACK (SDA high in the ninth clock), the target drives SDA no more until the next start.
- R10: The target changes its SDA drive only while SCL is low.
- R11: A repeated start (a start with no stop before it) restarts address decoding, and a read may follow a pointer write this way.
- R12: After an address that does not match, the target gives no ACK, makes no write and leaves the pointer unchanged until the next start.
- R13: While rstN is low, sdaDriveLow and regWrEn are 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; the strap pins are sampled while it is low |
| strap | input | 2 | Strap levels for the two low device address bits |
| sclIn | input | 1 | Bus clock pin level |
| sdaIn | input | 1 | Bus data pin level |
| sdaDriveLow | output | 1 | 1 pulls SDA low; 0 releases it |
| regWrEn | output | 1 | One-cycle write strobe to the register bank |
| regWrAddr | output | 4 | Register index for the write |
| regWrData | output | 8 | Byte to write |
| regRdAddr | output | 4 | Current pointer, used as the read index |
| regRdData | input | 8 | Bank contents at regRdAddr |

## Verification
All 128 device addresses are tried with a write direction, under one set of straps and then under a different reset-time strap value. Together these show that the fixed prefix and the latched straps are matched exactly, and that a non-matching transfer neither writes nor moves the pointer. Write bursts that cross index 15 and carry data from an arithmetic sequence show whether the pointer wraps and whether every byte lands at its own index. Reads with no setup, after an aborted write and after a repeated start show that the pointer persists and that only writes load it. Clocking the bus after a NACK shows whether the target keeps SDA released.

// File: rtl/i2cRegPkg.sv
`timescale 1ns/1ps
package i2cRegPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } ctrlState_t;

  // bus events seen on the system clock
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sclLevel;
    logic sdaLevel;
  } busEvent_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic setAck;
    logic relSda;
    logic latchDir;
    logic ptrLoad;
    logic ptrInc;
    logic regWrite;
  } dpStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic byteDone;
    logic addrMatch;
    logic dirRead;
  } dpStatus_t;

endpackage

// File: rtl/i2cBusSampler.sv
`timescale 1ns/1ps
module i2cBusSampler
  import i2cRegPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  output busEvent_t ev
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;
  logic sclNow;
  logic sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    ev.sclRise  = sclNow & ~sclPrev;
    ev.sclFall  = ~sclNow & sclPrev;
    ev.startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    ev.sclLevel = sclNow;
    ev.sdaLevel = sdaNow;
  end

endmodule

// File: rtl/i2cDatapath.sv
`timescale 1ns/1ps
module i2cDatapath
  import i2cRegPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PTR_W    = 4,
  parameter int STRAP_W  = 2,
  parameter int PREFIX_W = 5,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b10011
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strap,
  input  busEvent_t          ev,
  input  dpStrobe_t          strb,
  input  logic [DATA_W-1:0]  regRdData,
  output dpStatus_t          st,
  output logic [PTR_W-1:0]   ptr,
  output logic [DATA_W-1:0]  regWrData,
  output logic               sdaLow
);

  localparam int CNT_W      = $clog2(DATA_W + 1);
  localparam int DEV_ADDR_W = PREFIX_W + STRAP_W;

  logic [DATA_W-1:0]  shReg;
  logic [CNT_W-1:0]   bitCnt;
  logic               dirRead;
  logic [STRAP_W-1:0] strapLat;

  // straps captured while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) strapLat <= strap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (strb.loadTx) begin
      shReg  <= regRdData;
      bitCnt <= CNT_W'(1);
    end else if (strb.clrCnt) begin
      bitCnt <= '0;
    end else if (strb.shiftIn) begin
      shReg  <= {shReg[DATA_W-2:0], ev.sdaLevel};
      bitCnt <= bitCnt + 1'b1;
    end else if (strb.shiftTx) begin
      shReg  <= {shReg[DATA_W-2:0], 1'b0};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaLow <= 1'b0;
    end else begin
      if (strb.relSda)  sdaLow <= 1'b0;
      if (strb.setAck)  sdaLow <= 1'b1;
      if (strb.loadTx)  sdaLow <= ~regRdData[DATA_W-1];
      if (strb.shiftTx) sdaLow <= ~shReg[DATA_W-2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirRead <= 1'b0;
      ptr     <= '0;
    end else begin
      if (strb.latchDir) dirRead <= shReg[0];
      if (strb.ptrLoad)     ptr <= shReg[PTR_W-1:0];
      else if (strb.ptrInc) ptr <= ptr + 1'b1;
    end
  end

  assign regWrData    = shReg;
  assign st.byteDone  = (bitCnt == CNT_W'(DATA_W));
  assign st.addrMatch = (shReg[DATA_W-1:DATA_W-DEV_ADDR_W] == {ADDR_PREFIX, strapLat});
  assign st.dirRead   = dirRead;

  // R4: a ninth received bit is never shifted into a full byte
  p_no_ninth_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftIn |-> (bitCnt < CNT_W'(DATA_W)));

  // R3: the latched straps do not move once out of reset
  p_strap_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(strapLat));

endmodule

// File: rtl/i2cCtrl.sv
`timescale 1ns/1ps
module i2cCtrl
  import i2cRegPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  busEvent_t ev,
  input  dpStatus_t st,
  output dpStrobe_t strb
);

  ctrlState_t state, nxt;
  logic nackSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      nackSeen <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_RDATA_ACK && ev.sclRise) nackSeen <= ev.sdaLevel;
    end
  end

  always_comb begin
    strb = '0;
    nxt  = state;
    if (ev.stopDet) begin
      strb.relSda = 1'b1;
      strb.clrCnt = 1'b1;
      nxt = ST_IDLE;
    end else if (ev.startDet) begin
      strb.relSda = 1'b1;
      strb.clrCnt = 1'b1;
      nxt = ST_ADDR;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (ev.sclRise && !st.byteDone) begin
            strb.shiftIn = 1'b1;
          end else if (ev.sclFall && st.byteDone) begin
            if (state == ST_ADDR) begin
              if (st.addrMatch) begin
                strb.setAck   = 1'b1;
                strb.latchDir = 1'b1;
                nxt = ST_ADDR_ACK;
              end else begin
                strb.clrCnt = 1'b1;
                nxt = ST_IDLE;
              end
            end else if (state == ST_PTR) begin
              strb.ptrLoad = 1'b1;
              strb.setAck  = 1'b1;
              nxt = ST_PTR_ACK;
            end else begin
              strb.regWrite = 1'b1;
              strb.ptrInc   = 1'b1;
              strb.setAck   = 1'b1;
              nxt = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev.sclFall) begin
            strb.relSda = 1'b1;
            strb.clrCnt = 1'b1;
            if (st.dirRead) begin
              strb.loadTx = 1'b1;
              nxt = ST_RDATA;
            end else begin
              nxt = ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (ev.sclFall) begin
            strb.relSda = 1'b1;
            strb.clrCnt = 1'b1;
            nxt = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (ev.sclFall) begin
            if (st.byteDone) begin
              strb.relSda = 1'b1;
              strb.ptrInc = 1'b1;
              nxt = ST_RDATA_ACK;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (ev.sclFall) begin
            if (nackSeen) begin
              strb.clrCnt = 1'b1;
              nxt = ST_IDLE;
            end else begin
              strb.loadTx = 1'b1;
              nxt = ST_RDATA;
            end
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  // R8: the pointer is loaded only in a transfer addressed for write
  p_ptr_write_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrLoad |-> !st.dirRead);

  // R12: a mismatching address drops the target to idle
  p_nomatch_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && ev.sclFall && st.byteDone && !st.addrMatch
     && !ev.startDet && !ev.stopDet) |=> (state == ST_IDLE));

  // R9: a NACK from the controller ends the read
  p_nack_ends_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RDATA_ACK && ev.sclFall && nackSeen && !ev.startDet && !ev.stopDet)
    |=> (state == ST_IDLE));

endmodule

// File: rtl/i2cRegPort.sv
`timescale 1ns/1ps
module i2cRegPort
  import i2cRegPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PTR_W       = 4,
  parameter int STRAP_W     = 2,
  parameter int PREFIX_W    = 5,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b10011,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strap,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaDriveLow,
  output logic               regWrEn,
  output logic [PTR_W-1:0]   regWrAddr,
  output logic [DATA_W-1:0]  regWrData,
  output logic [PTR_W-1:0]   regRdAddr,
  input  logic [DATA_W-1:0]  regRdData
);

  busEvent_t        ev;
  dpStrobe_t        strb;
  dpStatus_t        st;
  logic [PTR_W-1:0] ptr;

  i2cBusSampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ev(ev)
  );

  i2cCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .st(st), .strb(strb)
  );

  i2cDatapath #(
    .DATA_W(DATA_W), .PTR_W(PTR_W), .STRAP_W(STRAP_W),
    .PREFIX_W(PREFIX_W), .ADDR_PREFIX(ADDR_PREFIX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strap(strap), .ev(ev), .strb(strb),
    .regRdData(regRdData), .st(st), .ptr(ptr),
    .regWrData(regWrData), .sdaLow(sdaDriveLow)
  );

  assign regWrEn   = strb.regWrite;
  assign regWrAddr = ptr;
  assign regRdAddr = ptr;

  // R1: a stop always leaves SDA released
  p_release_on_stop_r1: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopDet |=> !sdaDriveLow);

  // R10: the drive moves only while the sampled SCL is low
  p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDriveLow != $past(sdaDriveLow)) |->
      (!$past(ev.sclLevel) || $past(ev.startDet) || $past(ev.stopDet)));

  // R6: the pointer advances by one after each written byte
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdAddr == PTR_W'($past(regWrAddr) + 1'b1)));

endmodule

// File: tb/test_i2cRegPort.sv
`timescale 1ns/1ps
module test_i2cRegPort;

  localparam int Q = 8;
  localparam int WATCHDOG = 190000;
  localparam logic [4:0] PREFIX = 5'b10011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] strap = 2'b10;
  logic hostScl = 1'b1;
  logic hostSda = 1'b1;
  logic sdaLine;
  logic sdaDriveLow;
  logic regWrEn;
  logic [3:0] regWrAddr;
  logic [7:0] regWrData;
  logic [3:0] regRdAddr;
  logic [7:0] regRdData;

  logic [7:0] bank [16];
  logic [7:0] expReg [16];
  int wrCount = 0;
  int checks = 0;
  int failures = 0;
  int sclHighMoves = 0;
  int quietDrives = 0;
  logic quietWindow = 1'b0;
  logic prevDrv = 1'b0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  assign sdaLine = hostSda & ~sdaDriveLow;
  assign regRdData = bank[regRdAddr];

  i2cRegPort i_i2cRegPort (
    .clk(clk), .rstN(rstN), .strap(strap), .sclIn(hostScl), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  // register bank model
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) bank[i] <= 8'h00;
    end else if (regWrEn) begin
      bank[regWrAddr] <= regWrData;
      wrCount <= wrCount + 1;
    end
  end

  // bus monitors
  always @(negedge clk) begin
    if (rstN && hostScl && (sdaDriveLow != prevDrv)) sclHighMoves++;
    if (quietWindow && sdaDriveLow) quietDrives++;
    prevDrv = sdaDriveLow;
  end

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    hostSda = 1'b1; waitQ();
    hostScl = 1'b1; waitQ();
    hostSda = 1'b0; waitQ();
    hostScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    hostSda = 1'b0; waitQ();
    hostScl = 1'b1; waitQ();
    hostSda = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      hostSda = b[i]; waitQ();
      hostScl = 1'b1; waitQ(); waitQ();
      hostScl = 1'b0; waitQ();
    end
    hostSda = 1'b1; waitQ();
    hostScl = 1'b1; waitQ();
    acked = ~sdaLine; waitQ();
    hostScl = 1'b0; waitQ();
  endtask

  task automatic recvByte(output logic [7:0] b, input logic giveAck);
    hostSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      hostScl = 1'b1; waitQ();
      b[i] = sdaLine; waitQ();
      hostScl = 1'b0; waitQ();
    end
    hostSda = ~giveAck; waitQ();
    hostScl = 1'b1; waitQ(); waitQ();
    hostScl = 1'b0; waitQ();
    hostSda = 1'b1;
  endtask

  task automatic doReset(input logic [1:0] s);
    hostScl = 1'b1; hostSda = 1'b1;
    rstN = 1'b0; strap = s;
    repeat (10) @(negedge clk);
    // R13: reset state
    chk("R13", "sdaDriveLow in reset", int'(sdaDriveLow), 0);
    chk("R13", "regWrEn in reset", int'(regWrEn), 0);
    chk("R13", "pointer in reset", int'(regRdAddr), 0);
    rstN = 1'b1;
    strap = ~s;  // later strap changes must not matter
    for (int i = 0; i < 16; i++) expReg[i] = 8'h00;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all-reqs actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    logic [6:0] dev;
    int wrBase;

    doReset(2'b10);
    dev = {PREFIX, 2'b10};

    // R2/R12: sweep every 7-bit address with write direction
    for (int a = 0; a < 128; a++) begin
      busStart();
      sendByte({7'(a), 1'b0}, ack);
      chk("R2", "address ack", int'(ack), int'(7'(a) == dev));
      sendByte(8'h0F, ack);
      chk("R12", "pointer ack after address", int'(ack), int'(7'(a) == dev));
      busStop();
    end
    chk("R12", "no writes during sweep", wrCount, 0);
    chk("R7", "pointer after sweep", int'(regRdAddr), 15);

    // R4/R6: write burst of 18 bytes from index 3, wrapping
    busStart();
    sendByte({dev, 1'b0}, ack);
    chk("R2", "write address ack", int'(ack), 1);
    sendByte(8'hA3, ack);  // low nibble 3
    chk("R4", "pointer byte ack", int'(ack), 1);
    for (int k = 0; k < 18; k++) begin
      b = 8'(k * 29 + 7);
      expReg[(3 + k) % 16] = b;
      sendByte(b, ack);
      chk("R4", "data byte ack", int'(ack), 1);
    end
    busStop();
    for (int i = 0; i < 16; i++) chk("R4", "bank after burst", int'(bank[i]), int'(expReg[i]));
    chk("R6", "pointer after wrapped burst", int'(regRdAddr), 5);
    chk("R4", "write count", wrCount, 18);
    wrBase = wrCount;

    // R5/R7/R8: read with no setup continues from stored pointer
    busStart();
    sendByte({dev, 1'b1}, ack);
    chk("R2", "read address ack", int'(ack), 1);
    for (int k = 0; k < 4; k++) begin
      recvByte(b, k < 3);
      chk("R5", "read data", int'(b), int'(expReg[(5 + k) % 16]));
    end
    busStop();
    chk("R6", "pointer after read", int'(regRdAddr), 9);
    chk("R8", "no write during read", wrCount, wrBase);

    // R7: aborted write sets pointer, read wraps past 15
    busStart();
    sendByte({dev, 1'b0}, ack);
    sendByte(8'hFE, ack);
    busStop();
    chk("R7", "pointer after aborted write", int'(regRdAddr), 14);
    busStart();
    sendByte({dev, 1'b1}, ack);
    for (int k = 0; k < 4; k++) begin
      recvByte(b, k < 3);
      chk("R6", "read across wrap", int'(b), int'(expReg[(14 + k) % 16]));
    end
    // R9: after NACK the target stays off the bus
    quietWindow = 1'b1;
    recvByte(b, 1'b0);
    quietWindow = 1'b0;
    chk("R9", "line after nack", int'(b), 8'hFF);
    chk("R9", "drive cycles after nack", quietDrives, 0);
    busStop();
    chk("R6", "pointer after wrapped read", int'(regRdAddr), 2);

    // R11: repeated start from pointer write into read
    busStart();
    sendByte({dev, 1'b0}, ack);
    sendByte(8'h07, ack);
    busStart();
    sendByte({dev, 1'b1}, ack);
    chk("R11", "ack after repeated start", int'(ack), 1);
    recvByte(b, 1'b0);
    chk("R11", "data after repeated start", int'(b), int'(expReg[7]));
    busStop();

    // R11/R12: repeated start into a foreign address
    busStart();
    sendByte({dev, 1'b0}, ack);
    sendByte(8'h0A, ack);
    busStart();
    sendByte({dev ^ 7'h01, 1'b1}, ack);
    chk("R12", "no ack for foreign address", int'(ack), 0);
    sendByte(8'h55, ack);
    chk("R12", "no ack for following byte", int'(ack), 0);
    busStop();
    chk("R12", "pointer kept after foreign address", int'(regRdAddr), 10);
    chk("R8", "no write in foreign transfer", wrCount, wrBase);

    // R4/R5/R6: full 16-register pattern, wrap brings pointer back to 0
    busStart();
    sendByte({dev, 1'b0}, ack);
    sendByte(8'h00, ack);
    for (int i = 0; i < 16; i++) begin
      b = 8'(i * 17) ^ 8'h5A;
      expReg[i] = b;
      sendByte(b, ack);
    end
    busStop();
    chk("R6", "pointer wrapped to 0", int'(regRdAddr), 0);
    busStart();
    sendByte({dev, 1'b1}, ack);
    for (int i = 0; i < 16; i++) begin
      recvByte(b, i < 15);
      chk("R5", "pattern readback", int'(b), int'(expReg[i]));
    end
    busStop();

    // R3: second reset with other straps
    doReset(2'b01);
    busStart();
    sendByte({PREFIX, 2'b10, 1'b0}, ack);
    chk("R3", "old strap address rejected", int'(ack), 0);
    busStop();
    busStart();
    sendByte({PREFIX, 2'b01, 1'b0}, ack);
    chk("R3", "new strap address accepted", int'(ack), 1);
    sendByte(8'h04, ack);
    sendByte(8'hC3, ack);
    busStop();
    chk("R3", "write under new strap", int'(bank[4]), 8'hC3);

    chk("R10", "drive changes while SCL high", sclHighMoves, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule